// File: doc/BRIEF.md
# Counter Tap Interval Trigger

This block watches eight bits of a free-running counter that lives elsewhere. When a watched bit goes from 0 to 1 between two consecutive clock samples, the block can issue a single-cycle start pulse to an A/D converter, raise an interrupt source, or do both. Which of these happens is set by three 8-bit configuration registers, one per converter.

In each configuration byte, the high nibble selects which tapped bits start that register's converter. The low nibble selects which tapped bits raise interrupt sources. The first register watches counter bits 6 to 9. The second and third registers both watch counter bits 10 to 13. Every interrupt source has a sticky status bit that software clears by writing ones. The enabled status bits are merged onto one interrupt request line.

To use the block, connect the counter value and write the configuration registers. Then route the three start lines to the converters and the request line to the interrupt controller.

Top module: `tap_event_trig`

## Requirements
- R1: After reset, all configuration registers are zero, `adcStart` is 3'b000, `irqStatus` is 12'h000 and `irqReq` is 0.
- R2: An event is detected only when a tapped bit is 0 in one clock sample of `cntVal` and 1 in the next. The resulting output appears right after the clock edge that samples the 1.
- R3: Register 0 taps counter bits 6..9. Registers 1 and 2 both tap counter bits 10..13. Nibble bit k of a register maps to tapped bit base+k.
- R4: Configuration bits 7:4 enable converter starts. Register 0 drives `adcStart[2]`, register 1 drives `adcStart[0]` and register 2 drives `adcStart[1]`. Each start is a one-cycle pulse.
- R5: Configuration bits 3:0 enable interrupt sources. An enabled event on nibble bit k of register r sets `irqStatus[4*r+k]`.
- R6: A status bit stays set until a cycle in which `stsClrEn` is 1 and the matching bit of `stsClrData` is 1. That cycle clears it.
- R7: If an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R8: `irqReq` is 1 exactly when some status bit is set and the interrupt enable bit of that source is currently set. Status bits are kept when their enable is removed.
- R9: A register written to zero produces no starts and sets no status bits.
- R10: Falling transitions and transitions of counter bits outside 6..13 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntVal | input | 16 | Current free-running counter value |
| cfgWrEn | input | 3 | Per-register write strobe (bit r writes register r) |
| cfgWrData | input | 8 | Configuration byte to write |
| stsClrEn | input | 1 | Status clear strobe |
| stsClrData | input | 12 | Write-one-to-clear mask for status bits |
| adcStart | output | 3 | Converter start pulses, indexed by converter number |
| irqStatus | output | 12 | Sticky status bits, bit 4*r+k for register r, nibble bit k |
| irqReq | output | 1 | Merged interrupt request |

## Verification
The assertions assume that `cntVal` carries a known value on every clock edge after reset. They also assume that each sampled value is compared only with the one sampled just before it, so the checker's own two-deep history of the tapped window describes what the design saw. The bench meets this by changing the counter, strobes and data only a few nanoseconds after a rising edge, one value per cycle. It sets the counter directly instead of incrementing it, so that chosen rising, falling and untapped transitions can be placed in specific cycles. Configuration writes and clears are held for exactly one cycle while the counter stays constant, unless a test deliberately overlaps them.

// File: rtl/tap_event_pkg.sv
`timescale 1ns/1ps
package tap_event_pkg;
  localparam int NUM_CFG = 3;
  localparam int NIB_W   = 4;
  localparam int CFG_W   = 2 * NIB_W;
  localparam int STS_W   = NUM_CFG * NIB_W;

  typedef struct packed {
    logic [NUM_CFG-1:0][NIB_W-1:0] adcEn;
    logic [NUM_CFG-1:0][NIB_W-1:0] irqEn;
    logic [STS_W-1:0]              clrMask;
  } tapStrobes_t;

  // register index -> converter start line
  function automatic int convOf(input int idx);
    case (idx)
      0:       return 2;
      1:       return 0;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/tap_event_ctl.sv
`timescale 1ns/1ps
module tap_event_ctl
  import tap_event_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CFG-1:0] cfgWrEn,
  input  logic [CFG_W-1:0]   cfgWrData,
  input  logic               stsClrEn,
  input  logic [STS_W-1:0]   stsClrData,
  output tapStrobes_t        strb
);
  logic [NUM_CFG-1:0][CFG_W-1:0] cfgQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else begin
      for (int i = 0; i < NUM_CFG; i++) begin
        if (cfgWrEn[i]) cfgQ[i] <= cfgWrData;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CFG; i++) begin
      strb.adcEn[i] = cfgQ[i][CFG_W-1:NIB_W];
      strb.irqEn[i] = cfgQ[i][NIB_W-1:0];
    end
    strb.clrMask = stsClrEn ? stsClrData : '0;
  end
endmodule

// File: rtl/tap_event_dp.sv
`timescale 1ns/1ps
module tap_event_dp
  import tap_event_pkg::*;
#(
  parameter int LO_BASE = 6,
  parameter int HI_BASE = 10,
  parameter int WIN_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WIN_W-1:0]   tapWin,
  input  tapStrobes_t        strb,
  output logic [NUM_CFG-1:0] adcStart,
  output logic [STS_W-1:0]   irqStatus,
  output logic               irqReq
);
  logic [WIN_W-1:0]              prevWin;
  logic                          prevValid;
  logic [WIN_W-1:0]              riseWin;
  logic [NUM_CFG-1:0][NIB_W-1:0] tapRise;
  logic [NUM_CFG-1:0][NIB_W-1:0] stsSet;
  logic [NUM_CFG-1:0]            adcNext;
  logic [NUM_CFG-1:0]            adcQ;
  logic [STS_W-1:0]              stsQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevWin   <= '0;
      prevValid <= 1'b0;
    end else begin
      prevWin   <= tapWin;
      prevValid <= 1'b1;
    end
  end

  assign riseWin = prevValid ? (tapWin & ~prevWin) : '0;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_src
    localparam int OFS  = ((g == 0) ? LO_BASE : HI_BASE) - LO_BASE;
    localparam int CONV = convOf(g);
    assign tapRise[g]    = riseWin[OFS +: NIB_W];
    assign adcNext[CONV] = |(tapRise[g] & strb.adcEn[g]);
    assign stsSet[g]     = tapRise[g] & strb.irqEn[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      adcQ <= '0;
      stsQ <= '0;
    end else begin
      adcQ <= adcNext;
      stsQ <= (stsQ & ~strb.clrMask) | stsSet;
    end
  end

  assign adcStart  = adcQ;
  assign irqStatus = stsQ;
  assign irqReq    = |(stsQ & strb.irqEn);
endmodule

// File: rtl/tap_event_trig.sv
`timescale 1ns/1ps
module tap_event_trig
  import tap_event_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int LO_BASE = 6,
  parameter int HI_BASE = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   cntVal,
  input  logic [NUM_CFG-1:0] cfgWrEn,
  input  logic [CFG_W-1:0]   cfgWrData,
  input  logic               stsClrEn,
  input  logic [STS_W-1:0]   stsClrData,
  output logic [NUM_CFG-1:0] adcStart,
  output logic [STS_W-1:0]   irqStatus,
  output logic               irqReq
);
  localparam int WIN_HI = HI_BASE + NIB_W - 1;
  localparam int WIN_W  = WIN_HI - LO_BASE + 1;

  tapStrobes_t    strb;
  logic           unusedCntBits;

  assign unusedCntBits = ^{cntVal[LO_BASE-1:0], cntVal[CNT_W-1:WIN_HI+1]};

  tap_event_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .stsClrEn   (stsClrEn),
    .stsClrData (stsClrData),
    .strb       (strb)
  );

  tap_event_dp #(
    .LO_BASE (LO_BASE),
    .HI_BASE (HI_BASE),
    .WIN_W   (WIN_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tapWin    (cntVal[WIN_HI:LO_BASE]),
    .strb      (strb),
    .adcStart  (adcStart),
    .irqStatus (irqStatus),
    .irqReq    (irqReq)
  );
endmodule

// File: rtl/tap_event_chk.sv
`timescale 1ns/1ps
module tap_event_chk
  import tap_event_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [WIN_W-1:0]   tapWin,
  input logic               stsClrEn,
  input logic [STS_W-1:0]   stsClrData,
  input logic [NUM_CFG-1:0] adcStart,
  input logic [STS_W-1:0]   irqStatus,
  input logic               irqReq
);
  logic [WIN_W-1:0] tapD1, tapD2, riseD;
  logic [STS_W-1:0] riseMap, clrNow;

  always_ff @(posedge clk) begin
    tapD1 <= tapWin;
    tapD2 <= tapD1;
  end

  assign riseD   = tapD1 & ~tapD2;
  assign riseMap = {riseD[WIN_W-1 -: NIB_W], riseD[WIN_W-1 -: NIB_W], riseD[NIB_W-1:0]};
  assign clrNow  = stsClrEn ? stsClrData : '0;

  AST_START2_FROM_LOW_TAPS: assert property (@(posedge clk) disable iff (!rstN)
    adcStart[2] |-> |riseD[NIB_W-1:0]); // R4
  AST_START0_FROM_HIGH_TAPS: assert property (@(posedge clk) disable iff (!rstN)
    adcStart[0] |-> |riseD[WIN_W-1 -: NIB_W]); // R3
  AST_START1_FROM_HIGH_TAPS: assert property (@(posedge clk) disable iff (!rstN)
    adcStart[1] |-> |riseD[WIN_W-1 -: NIB_W]); // R3
  AST_STATUS_SET_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rstN)
    ((irqStatus & ~$past(irqStatus)) & ~riseMap) == '0); // R5
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (($past(irqStatus) & ~$past(clrNow)) & ~irqStatus) == '0); // R6
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqStatus != '0)); // R8
endmodule

bind tap_event_trig tap_event_chk #(.WIN_W(HI_BASE + tap_event_pkg::NIB_W - LO_BASE)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tapWin     (cntVal[HI_BASE + tap_event_pkg::NIB_W - 1:LO_BASE]),
  .stsClrEn   (stsClrEn),
  .stsClrData (stsClrData),
  .adcStart   (adcStart),
  .irqStatus  (irqStatus),
  .irqReq     (irqReq)
);

// File: tb/tap_event_trig_bench.sv
`timescale 1ns/1ps
module tap_event_trig_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cntVal = '0;
  logic [2:0]  cfgWrEn = '0;
  logic [7:0]  cfgWrData = '0;
  logic        stsClrEn = 1'b0;
  logic [11:0] stsClrData = '0;
  logic [2:0]  adcStart;
  logic [11:0] irqStatus;
  logic        irqReq;

  int testCnt = 0;
  int failCnt = 0;

  always #5 clk = ~clk;

  tap_event_trig u_tap_event_trig (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .stsClrEn(stsClrEn), .stsClrData(stsClrData),
    .adcStart(adcStart), .irqStatus(irqStatus), .irqReq(irqReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] v);
    cntVal = v;
    @(posedge clk); #2;
  endtask

  task automatic wrCfg(input int idx, input logic [7:0] d);
    cfgWrEn = '0; cfgWrEn[idx] = 1'b1; cfgWrData = d;
    @(posedge clk); #2;
    cfgWrEn = '0;
  endtask

  task automatic clrSts(input logic [11:0] m);
    stsClrEn = 1'b1; stsClrData = m;
    @(posedge clk); #2;
    stsClrEn = 1'b0; stsClrData = '0;
  endtask

  task automatic tReset();
    chk("R1 adcStart", adcStart, 0);
    chk("R1 irqStatus", irqStatus, 0);
    chk("R1 irqReq", irqReq, 0);
  endtask

  task automatic tReg0Start();
    wrCfg(0, 8'h10);
    step(16'h0000);
    step(16'h0040);
    chk("R4 reg0 to conv2", adcStart, 3'b100);
    chk("R5 no irq enable", irqStatus, 0);
    step(16'h0040);
    chk("R4 single pulse", adcStart, 0);
    step(16'h0000);
    chk("R10 falling ignored", adcStart, 0);
  endtask

  task automatic tSticky();
    wrCfg(1, 8'h04);
    step(16'h0000);
    step(16'h1000);
    chk("R5 status bit 6", irqStatus, 12'h040);
    chk("R8 irqReq set", irqReq, 1);
    chk("R2 no start", adcStart, 0);
    step(16'h0000);
    step(16'h0000);
    chk("R6 status held", irqStatus, 12'h040);
    clrSts(12'h040);
    chk("R6 cleared", irqStatus, 0);
    chk("R8 irqReq low", irqReq, 0);
  endtask

  task automatic tCollide();
    cntVal = 16'h1000; stsClrEn = 1'b1; stsClrData = 12'h040;
    @(posedge clk); #2;
    stsClrEn = 1'b0; stsClrData = '0;
    chk("R7 event beats clear", irqStatus, 12'h040);
    clrSts(12'h040);
    chk("R7 later clear", irqStatus, 0);
    step(16'h0000);
  endtask

  task automatic tShared();
    wrCfg(1, 8'h80);
    wrCfg(2, 8'h80);
    step(16'h0000);
    step(16'h2000);
    chk("R3 shared taps conv0 conv1", adcStart, 3'b011);
    chk("R5 no status", irqStatus, 0);
    step(16'h0000);
  endtask

  task automatic tMaskAndMulti();
    wrCfg(0, 8'h0F);
    step(16'h03C0);
    chk("R3 reg0 four taps", irqStatus, 12'h00F);
    chk("R8 irqReq", irqReq, 1);
    wrCfg(0, 8'h00);
    chk("R8 enable removed", irqReq, 0);
    chk("R8 status kept", irqStatus, 12'h00F);
    wrCfg(0, 8'h0F);
    chk("R8 enable restored", irqReq, 1);
    clrSts(12'hFFF);
    chk("R6 clear all", irqStatus, 0);
    step(16'h0000);
  endtask

  task automatic tZero();
    wrCfg(0, 8'h00); wrCfg(1, 8'h00); wrCfg(2, 8'h00);
    step(16'h0000);
    step(16'h3FC0);
    chk("R9 no start", adcStart, 0);
    chk("R9 no status", irqStatus, 0);
    chk("R9 no irq", irqReq, 0);
  endtask

  task automatic tUntapped();
    wrCfg(0, 8'hFF); wrCfg(1, 8'hFF); wrCfg(2, 8'hFF);
    step(16'h0000);
    step(16'hC03F);
    chk("R10 untapped start", adcStart, 0);
    chk("R10 untapped status", irqStatus, 0);
    step(16'hFFFF);
    chk("R2 all taps start", adcStart, 3'b111);
    chk("R2 all taps status", irqStatus, 12'hFFF);
    chk("R8 all taps irq", irqReq, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    tReset();
    tReg0Start();
    tSticky();
    tCollide();
    tShared();
    tMaskAndMulti();
    tZero();
    tUntapped();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #100000;
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule